// File: doc/BRIEF.md
# Phase-Correct PWM Timer

This block is an 8-bit up/down counter that produces a center-aligned, symmetric pulse-width waveform. The counter climbs from zero to its top value, then descends back to zero. Both turnarounds are visited once, so one waveform period takes 510 timer steps. The counter advances only on cycles where an internal prescaler issues a step enable. That enable is derived from the single system clock by a selectable divide factor. No second clock is involved.

Software supplies a threshold through a write strobe. The threshold first lands in a holding register. It becomes active only when the counter arrives at its top value, so a period never mixes two thresholds. The output level flips when the counter passes the active threshold: low on the way up and high on the way down, or the reverse under a polarity input. A threshold of zero or of the top value gives a constant level. At the top turnaround the level is always forced to the rising-side result. This keeps the waveform symmetric even when a crossing was skipped, for example when the threshold leaves the top value.

A sticky flag records each arrival at zero. Software clears it with a clear strobe.

Top module: `sympwm_timer`

## Requirements
- R1: The count steps by exactly one per step enable in the order 0,1,…,255,254,…,1,0,1,…. `dir_up_o` is 1 at count 0, 0 at count 255, and otherwise shows the direction of the last step.
- R2: `ps_sel_i` codes 0..6 select a step every 1, 8, 32, 64, 128, 256 or 1024 system clocks. Code 7 halts the count.
- R3: A change of `ps_sel_i` restarts the divider. The first step under the new code comes N clocks after the edge that samples the change.
- R4: With a steady select, the count returns to zero every 510×N system clocks.
- R5: With `inv_i`=0 and active threshold C strictly between 0 and 255, `pwm_o` is 1 exactly while counting up with count < C, or counting down with count ≤ C.
- R6: An active threshold of 0 holds the level low. An active threshold of 255 holds it high.
- R7: `inv_i`=1 inverts `pwm_o` relative to R5 and R6, and takes effect immediately.
- R8: A threshold written through `cmp_wr_i`/`cmp_data_i` has no effect on `pwm_o` until the count next reaches 255. At that point it becomes active.
- R9: On arrival at 255, the level takes the rising-side value for the new threshold: high only if it is 255. A change from 255 to a lower threshold therefore makes a falling edge at the top with no crossing.
- R10: `ovf_o` sets in the cycle the count arrives at 0 and stays set until `ovf_clr_i` is pulsed. A simultaneous arrival wins over the clear.
- R11: While `rst_ni` is low: count 0, `dir_up_o` 1, `ovf_o` 0, and the level low (`pwm_o` = `inv_i`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ps_sel_i | input | 3 | Divide code: 0..6 for N = 1,8,32,64,128,256,1024; 7 halts |
| inv_i | input | 1 | Output polarity inversion |
| cmp_wr_i | input | 1 | Write strobe for the threshold holding register |
| cmp_data_i | input | 8 | Threshold value to hold |
| ovf_clr_i | input | 1 | Clears the zero-arrival flag |
| pwm_o | output | 1 | Waveform output |
| cnt_o | output | 8 | Current count |
| dir_up_o | output | 1 | 1 while counting up |
| ovf_o | output | 1 | Sticky zero-arrival flag |

## Verification
A wrong direction bit or count shows as a broken step on `cnt_o` at the very next step enable. A divider that fails to restart shows on the first step after a select change. A threshold loaded at the wrong moment, or a missing forced level at the top, appears on `pwm_o` within the same half-period. It shows either as an edge at an unexpected count or as a missing falling edge at 255. The bench recomputes the expected level in every cycle from the observed count and its own record of the written thresholds. It therefore catches a stale level within one clock.

// File: rtl/sympwm_pkg.sv
package sympwm_pkg;

   localparam int unsigned PS_CNT_W = 10;

   typedef enum logic [2:0] {
      PS_DIV1    = 3'd0,
      PS_DIV8    = 3'd1,
      PS_DIV32   = 3'd2,
      PS_DIV64   = 3'd3,
      PS_DIV128  = 3'd4,
      PS_DIV256  = 3'd5,
      PS_DIV1024 = 3'd6,
      PS_HALT    = 3'd7
   } ps_sel_e;

   // Last divider value before a step, i.e. N-1 for the chosen code.
   function automatic logic [PS_CNT_W-1:0] ps_last(input logic [2:0] sel);
      case (sel)
         3'd0:    ps_last = 10'd0;
         3'd1:    ps_last = 10'd7;
         3'd2:    ps_last = 10'd31;
         3'd3:    ps_last = 10'd63;
         3'd4:    ps_last = 10'd127;
         3'd5:    ps_last = 10'd255;
         3'd6:    ps_last = 10'd1023;
         default: ps_last = 10'd0;
      endcase
   endfunction

endpackage

// File: rtl/sympwm_prescale.sv
module sympwm_prescale
   import sympwm_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [2:0] sel_i,
   output logic       tick_o
);

   logic [PS_CNT_W-1:0] div_q;
   logic [2:0]          sel_q;
   logic                sel_chg;
   logic                run;

   assign sel_chg = (sel_i != sel_q);
   assign run     = (sel_q != PS_HALT);
   assign tick_o  = run && !sel_chg && (div_q == ps_last(sel_q));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         div_q <= '0;
         sel_q <= PS_DIV1;
      end else begin
         sel_q <= sel_i;
         if (sel_chg || tick_o || !run) div_q <= '0;
         else                           div_q <= div_q + 1'b1;
      end
   end

   // With a divide factor above one, steps never come on adjacent cycles.
   AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_o && sel_q != PS_DIV1) |=> !tick_o);   // R2

endmodule

// File: rtl/sympwm_updown.sv
module sympwm_updown #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             ovf_clr_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cnt_nxt_o,
   output logic             up_o,
   output logic             ovf_o,
   output logic             reach_max_o,
   output logic             reach_bot_o
);

   localparam logic [CNT_W-1:0] TOP = '1;
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             up_q;
   logic             ovf_q;

   assign cnt_nxt_o   = up_q ? cnt_q + ONE : cnt_q - ONE;
   assign reach_max_o = tick_i &&  up_q && (cnt_nxt_o == TOP);
   assign reach_bot_o = tick_i && !up_q && (cnt_nxt_o == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         up_q  <= 1'b1;
         ovf_q <= 1'b0;
      end else begin
         if (tick_i) begin
            cnt_q <= cnt_nxt_o;
            if (reach_max_o)      up_q <= 1'b0;
            else if (reach_bot_o) up_q <= 1'b1;
         end
         if (reach_bot_o)    ovf_q <= 1'b1;
         else if (ovf_clr_i) ovf_q <= 1'b0;
      end
   end

   assign cnt_o = cnt_q;
   assign up_o  = up_q;
   assign ovf_o = ovf_q;

   AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + ONE || cnt_q == $past(cnt_q) - ONE));   // R1
   AST_TOP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == TOP) |-> !up_q);   // R1
   AST_BOT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == '0) |-> up_q);   // R1
   AST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(cnt_q));   // R2
   AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reach_bot_o |=> ovf_q);   // R10

endmodule

// File: rtl/sympwm_wave.sv
module sympwm_wave #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             up_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] cnt_nxt_i,
   input  logic             reach_max_i,
   input  logic             reach_bot_i,
   input  logic             cmp_wr_i,
   input  logic [CNT_W-1:0] cmp_data_i,
   input  logic             inv_i,
   output logic             pwm_o
);

   localparam logic [CNT_W-1:0] TOP = '1;

   logic [CNT_W-1:0] cmp_buf_q;
   logic [CNT_W-1:0] cmp_act_q;
   logic             lvl_q;
   logic             mid_range;

   assign mid_range = (cmp_act_q != '0) && (cmp_act_q != TOP);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cmp_buf_q <= '0;
         cmp_act_q <= '0;
         lvl_q     <= 1'b0;
      end else begin
         if (cmp_wr_i) cmp_buf_q <= cmp_data_i;
         if (reach_max_i) begin
            // Top turnaround: load new threshold, take its rising-side level.
            cmp_act_q <= cmp_buf_q;
            lvl_q     <= (cmp_buf_q == TOP);
         end else if (reach_bot_i) begin
            // Bottom turnaround: falling-side level of the active threshold.
            lvl_q <= (cmp_act_q != '0);
         end else if (tick_i && mid_range && cnt_nxt_i == cmp_act_q) begin
            lvl_q <= !up_i;
         end
      end
   end

   assign pwm_o = lvl_q ^ inv_i;

   AST_LOAD_AT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmp_act_q != $past(cmp_act_q)) |-> (cnt_i == TOP));   // R8
   AST_CONST_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmp_act_q == '0) |-> !lvl_q);   // R6
   AST_CONST_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmp_act_q == TOP) |-> lvl_q);   // R6

endmodule

// File: rtl/sympwm_timer.sv
module sympwm_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [2:0]       ps_sel_i,
   input  logic             inv_i,
   input  logic             cmp_wr_i,
   input  logic [CNT_W-1:0] cmp_data_i,
   input  logic             ovf_clr_i,
   output logic             pwm_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             dir_up_o,
   output logic             ovf_o
);

   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
      $error("sympwm_timer: CNT_W must lie in 2..16");
   end

   logic             tick;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_nxt;
   logic             up;
   logic             reach_max;
   logic             reach_bot;

   sympwm_prescale u_presc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (ps_sel_i),
      .tick_o (tick)
   );

   sympwm_updown #(.CNT_W(CNT_W)) u_cnt (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick),
      .ovf_clr_i   (ovf_clr_i),
      .cnt_o       (cnt),
      .cnt_nxt_o   (cnt_nxt),
      .up_o        (up),
      .ovf_o       (ovf_o),
      .reach_max_o (reach_max),
      .reach_bot_o (reach_bot)
   );

   sympwm_wave #(.CNT_W(CNT_W)) u_wave (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick),
      .up_i        (up),
      .cnt_i       (cnt),
      .cnt_nxt_i   (cnt_nxt),
      .reach_max_i (reach_max),
      .reach_bot_i (reach_bot),
      .cmp_wr_i    (cmp_wr_i),
      .cmp_data_i  (cmp_data_i),
      .inv_i       (inv_i),
      .pwm_o       (pwm_o)
   );

   assign cnt_o    = cnt;
   assign dir_up_o = up;

endmodule

// File: tb/sympwm_timer_tb_top.sv
`timescale 1ns/1ps
module sympwm_timer_tb_top;

   localparam int TOPV = 255;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] ps_sel = 3'd0;
   logic       inv = 1'b0;
   logic       cmp_wr = 1'b0;
   logic [7:0] cmp_data = 8'd0;
   logic       ovf_clr = 1'b0;
   logic       pwm_o;
   logic [7:0] cnt_o;
   logic       dir_up_o;
   logic       ovf_o;

   sympwm_timer dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .ps_sel_i   (ps_sel),
      .inv_i      (inv),
      .cmp_wr_i   (cmp_wr),
      .cmp_data_i (cmp_data),
      .ovf_clr_i  (ovf_clr),
      .pwm_o      (pwm_o),
      .cnt_o      (cnt_o),
      .dir_up_o   (dir_up_o),
      .ovf_o      (ovf_o)
   );

   always #2.5 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   bit mon_en = 1'b0;
   int m_buf = 0;
   int m_act = 0;
   int p_cnt = 0;
   bit p_dir = 1'b1;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Per-cycle model: count step, direction, level, flag on arrival at zero.
   int    mc;
   int    mstep;
   bit    mdir;
   bit    mlvl;
   string mtag;
   always @(negedge clk) begin
      if (mon_en) begin
         mc = int'(cnt_o);
         if (mc != p_cnt) begin
            mstep = p_dir ? p_cnt + 1 : p_cnt - 1;
            chk(mc == mstep, "R1 count step", mc, mstep);
            if (mc == TOPV) m_act = m_buf;                         // R8 load point
            if (mc == 0 && p_cnt == 1)
               chk(ovf_o == 1'b1, "R10 flag on arrival", int'(ovf_o), 1);
         end
         mdir = (mc == 0) ? 1'b1 : (mc == TOPV) ? 1'b0 : p_dir;
         chk(dir_up_o == mdir, "R1 direction", int'(dir_up_o), int'(mdir));
         mlvl = mdir ? (mc < m_act) : (mc <= m_act && m_act != 0);
         if (inv)                            mtag = "R7 inverted level";
         else if (m_act == 0 || m_act == TOPV) mtag = "R6 constant level";
         else                                mtag = "R5 level";
         chk(pwm_o == (mlvl ^ inv), mtag, int'(pwm_o), int'(mlvl ^ inv));
         p_cnt = mc;
         p_dir = mdir;
      end
   end

   task automatic wait_cnt(input int v, input bit up);
      do @(negedge clk); while (!(int'(cnt_o) == v && dir_up_o == up));
   endtask

   task automatic write_cmp(input int v);
      @(posedge clk); #1;
      cmp_wr = 1'b1; cmp_data = 8'(v); m_buf = v;
      @(posedge clk); #1;
      cmp_wr = 1'b0;
   endtask

   task automatic set_sel(input int s);
      @(posedge clk); #1;
      ps_sel = 3'(s);
   endtask

   function automatic int div_of(input int s);
      case (s)
         0: return 1;
         1: return 8;
         2: return 32;
         3: return 64;
         4: return 128;
         5: return 256;
         default: return 1024;
      endcase
   endfunction

   task automatic measure_period(input int s);
      int n;
      wait_cnt(1, 1'b0);
      wait_cnt(0, 1'b1);
      n = 0;
      do begin @(negedge clk); n++; end while (cnt_o == 8'd0);
      do begin @(negedge clk); n++; end while (cnt_o != 8'd0);
      chk(n == 510 * div_of(s), "R4 period", n, 510 * div_of(s));
   endtask

   int cl[11] = '{0, 1, 2, 3, 64, 127, 128, 200, 253, 254, 255};

   initial begin
      int v;
      int n;
      // R11: reset state
      repeat (3) @(negedge clk);
      chk(cnt_o == 8'd0, "R11 count", int'(cnt_o), 0);
      chk(dir_up_o == 1'b1, "R11 direction", int'(dir_up_o), 1);
      chk(ovf_o == 1'b0, "R11 flag", int'(ovf_o), 0);
      chk(pwm_o == 1'b0, "R11 level", int'(pwm_o), 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      mon_en = 1'b1;

      // Threshold sweep under both polarities (R5, R6, R7 via monitor)
      for (int p = 0; p < 2; p++) begin
         for (int i = 0; i < 11; i++) begin
            wait_cnt(10, 1'b1);
            @(posedge clk); #1;
            inv = p[0];
            write_cmp(cl[i]);
            wait_cnt(TOPV, 1'b0);
         end
      end
      @(posedge clk); #1;
      inv = 1'b0;

      // R8 and R9: hold, then forced falling edge when leaving 255
      wait_cnt(10, 1'b1);
      write_cmp(255);
      wait_cnt(TOPV, 1'b0);
      wait_cnt(10, 1'b1);
      chk(pwm_o == 1'b1, "R6 high at 255", int'(pwm_o), 1);
      write_cmp(100);
      wait_cnt(150, 1'b1);
      chk(pwm_o == 1'b1, "R8 written value not yet active", int'(pwm_o), 1);
      wait_cnt(254, 1'b1);
      chk(pwm_o == 1'b1, "R9 level before top", int'(pwm_o), 1);
      wait_cnt(TOPV, 1'b0);
      chk(pwm_o == 1'b0, "R9 forced low at top", int'(pwm_o), 0);
      wait_cnt(100, 1'b0);
      chk(pwm_o == 1'b1, "R5 set on falling crossing", int'(pwm_o), 1);

      // R10: sticky flag, clear, set wins over clear
      wait_cnt(0, 1'b1);
      wait_cnt(5, 1'b1);
      chk(ovf_o == 1'b1, "R10 sticky", int'(ovf_o), 1);
      @(posedge clk); #1; ovf_clr = 1'b1;
      @(posedge clk); #1; ovf_clr = 1'b0;
      @(negedge clk);
      chk(ovf_o == 1'b0, "R10 cleared", int'(ovf_o), 0);
      wait_cnt(100, 1'b1);
      chk(ovf_o == 1'b0, "R10 stays clear", int'(ovf_o), 0);
      wait_cnt(3, 1'b0);
      @(posedge clk); #1; ovf_clr = 1'b1;
      wait_cnt(0, 1'b1);
      chk(ovf_o == 1'b1, "R10 set wins over clear", int'(ovf_o), 1);
      @(posedge clk); #1; ovf_clr = 1'b0;
      @(negedge clk);
      chk(ovf_o == 1'b0, "R10 clear after arrival", int'(ovf_o), 0);

      // R4: period for N=1 and N=8
      measure_period(0);
      set_sel(1);
      measure_period(1);

      // R2, R3: each divide code, restart on change, halt
      for (int s = 0; s < 7; s++) begin
         set_sel(7);
         repeat (3) @(negedge clk);
         v = int'(cnt_o);
         set_sel(s);
         n = 0;
         do begin @(negedge clk); n++; end while (int'(cnt_o) == v && n < 3000);
         chk(n == div_of(s) + 2, "R3 first step after select change", n, div_of(s) + 2);
         v = int'(cnt_o);
         n = 0;
         do begin @(negedge clk); n++; end while (int'(cnt_o) == v && n < 3000);
         chk(n == div_of(s), "R2 step spacing", n, div_of(s));
      end
      set_sel(7);
      @(negedge clk);
      v = int'(cnt_o);
      repeat (60) @(negedge clk);
      chk(int'(cnt_o) == v, "R2 halt code", int'(cnt_o), v);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #950000;
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule